// File: doc/BRIEF.md
# Cross-Clock Bypass Mailbox

This block carries one data word at a time from a writer running on clock A to a reader running on clock B. No FIFO storage is involved. When the writer has selected bypass operation, a qualified write loads the word into a single mailbox register. A request toggle then crosses into the clock B domain, where it raises an "available" flag. The reader takes the word with a qualified read, and an acknowledge toggle crosses back to clock A.

On the writer side, a "free" flag is low from the moment a word is posted until the reader has taken it. While that flag is low, any further write is dropped. The block also brings the writer's bypass selection over to the clock B side, where it appears as an active-low mode indicator. Each word that is written is matched by exactly one read.

Top module: `bypass_mailbox`

## Requirements
- R1: A write is accepted at a rising clk_a_i edge when byp_mode_i=1, a_en_ni=0, a_rw_i=0 and a_free_o=1. That edge loads a_data_i into the mailbox, and a_free_o is 0 after it.
- R2: After an accepted write, b_avail_o goes to 1 no later than the third rising clk_b_i edge.
- R3: A read is accepted at a rising clk_b_i edge when b_avail_o=1, b_en_ni=0 and b_rw_i=1. That edge places the posted word on b_data_o, and b_avail_o is 0 after it.
- R4: After an accepted read, a_free_o returns to 1 no later than the fourth rising clk_a_i edge.
- R5: A write attempted while a_free_o=0 is ignored. The pending word is the one the next read returns.
- R6: A write strobe is ignored if byp_mode_i=0, a_en_ni=1 or a_rw_i=1. In that case a_free_o stays 1 and b_avail_o stays 0.
- R7: A read strobe is ignored if b_avail_o=0, b_en_ni=1 or b_rw_i=0. In that case b_data_o holds its value, and b_avail_o does not drop.
- R8: b_byp_no is the inverse of byp_mode_i, passed through SYNC_STAGES clk_b_i flops. It follows a change within three clk_b_i edges.
- R9: While rst_ni=0, b_avail_o=0, a_free_o=1, b_data_o=0 and b_byp_no=1.
- R10: Each accepted write yields exactly one accepted read. After a read, b_avail_o stays 0 until a new write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | Writer clock |
| clk_b_i | input | 1 | Reader clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byp_mode_i | input | 1 | Bypass select, clock A domain |
| a_en_ni | input | 1 | Writer enable, active low |
| a_rw_i | input | 1 | Writer direction, 0 = write |
| a_data_i | input | DATA_W | Word to post |
| a_free_o | output | 1 | 1 = mailbox free, 0 = word pending |
| b_en_ni | input | 1 | Reader enable, active low |
| b_rw_i | input | 1 | Reader direction, 1 = read |
| b_data_o | output | DATA_W | Last word read |
| b_avail_o | output | 1 | 1 = word available to the reader |
| b_byp_no | output | 1 | 0 = bypass mode active |

## Verification
The main write/read round trip is driven with walking-one and walking-zero words, plus all-zeros and all-ones. Together these show that every data bit is carried on its own, with no stuck or swapped bits. Each round trip measures how many clock edges the available and free flags take against their bounds. Separate patterns apply each disqualifying strobe combination on both sides, and also a second write while a word is still pending. These show that the gating is correct and that a pending word is never overwritten. The bypass indicator is toggled in both directions to confirm its polarity and its latency.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  parameter int unsigned MBOX_DW     = 18;
  parameter int unsigned MBOX_STAGES = 2;
endpackage

// File: rtl/mbox_sync.sv
module mbox_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/mbox_wr_side.sv
module mbox_wr_side #(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byp_mode_i,
  input  logic              en_ni,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ack_sync_i,
  output logic              req_tgl_o,
  output logic [DATA_W-1:0] mbox_o,
  output logic              free_o
);
  logic              req_q;
  logic [DATA_W-1:0] mbox_q;
  logic              wr_fire;

  assign free_o  = (req_q == ack_sync_i);
  assign wr_fire = byp_mode_i & ~en_ni & ~rw_i & free_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      mbox_q <= '0;
    end else if (wr_fire) begin
      req_q  <= ~req_q;
      mbox_q <= data_i;
    end
  end

  assign req_tgl_o = req_q;
  assign mbox_o    = mbox_q;
endmodule

// File: rtl/mbox_rd_side.sv
module mbox_rd_side #(
  parameter int unsigned DATA_W = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_ni,
  input  logic              rw_i,
  input  logic              req_sync_i,
  input  logic [DATA_W-1:0] mbox_i,
  output logic              ack_tgl_o,
  output logic [DATA_W-1:0] data_o,
  output logic              avail_o
);
  logic              ack_q;
  logic [DATA_W-1:0] data_q;
  logic              rd_fire;

  assign avail_o = (req_sync_i != ack_q);
  assign rd_fire = avail_o & ~en_ni & rw_i;

  // mbox_i is stable while avail_o is high: sampled only then
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      data_q <= '0;
    end else if (rd_fire) begin
      ack_q  <= ~ack_q;
      data_q <= mbox_i;
    end
  end

  assign ack_tgl_o = ack_q;
  assign data_o    = data_q;
endmodule

// File: rtl/bypass_mailbox.sv
module bypass_mailbox
  import mbox_pkg::*;
#(
  parameter int unsigned DATA_W      = MBOX_DW,
  parameter int unsigned SYNC_STAGES = MBOX_STAGES
) (
  input  logic              clk_a_i,
  input  logic              clk_b_i,
  input  logic              rst_ni,
  input  logic              byp_mode_i,
  input  logic              a_en_ni,
  input  logic              a_rw_i,
  input  logic [DATA_W-1:0] a_data_i,
  output logic              a_free_o,
  input  logic              b_en_ni,
  input  logic              b_rw_i,
  output logic [DATA_W-1:0] b_data_o,
  output logic              b_avail_o,
  output logic              b_byp_no
);
  logic              req_tgl, req_sync;
  logic              ack_tgl, ack_sync;
  logic              byp_sync;
  logic [DATA_W-1:0] mbox_q;

  mbox_wr_side #(.DATA_W(DATA_W)) u_wr (
    .clk_i      (clk_a_i),
    .rst_ni     (rst_ni),
    .byp_mode_i (byp_mode_i),
    .en_ni      (a_en_ni),
    .rw_i       (a_rw_i),
    .data_i     (a_data_i),
    .ack_sync_i (ack_sync),
    .req_tgl_o  (req_tgl),
    .mbox_o     (mbox_q),
    .free_o     (a_free_o)
  );

  mbox_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_req_sync (
    .clk_i  (clk_b_i),
    .rst_ni (rst_ni),
    .d_i    (req_tgl),
    .q_o    (req_sync)
  );

  mbox_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_ack_sync (
    .clk_i  (clk_a_i),
    .rst_ni (rst_ni),
    .d_i    (ack_tgl),
    .q_o    (ack_sync)
  );

  mbox_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_byp_sync (
    .clk_i  (clk_b_i),
    .rst_ni (rst_ni),
    .d_i    (byp_mode_i),
    .q_o    (byp_sync)
  );

  mbox_rd_side #(.DATA_W(DATA_W)) u_rd (
    .clk_i      (clk_b_i),
    .rst_ni     (rst_ni),
    .en_ni      (b_en_ni),
    .rw_i       (b_rw_i),
    .req_sync_i (req_sync),
    .mbox_i     (mbox_q),
    .ack_tgl_o  (ack_tgl),
    .data_o     (b_data_o),
    .avail_o    (b_avail_o)
  );

  assign b_byp_no = ~byp_sync;
endmodule

// File: rtl/bypass_mailbox_chk.sv
module bypass_mailbox_chk #(
  parameter int unsigned DATA_W = 18
) (
  input logic              clk_a_i,
  input logic              clk_b_i,
  input logic              rst_ni,
  input logic              byp_mode_i,
  input logic              a_en_ni,
  input logic              a_rw_i,
  input logic              a_free_o,
  input logic              b_en_ni,
  input logic              b_rw_i,
  input logic [DATA_W-1:0] b_data_o,
  input logic              b_avail_o,
  input logic [DATA_W-1:0] mbox_q
);
  a_r1_free_falls: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_free_o && byp_mode_i && !a_en_ni && !a_rw_i) |=> !a_free_o);

  a_r6_no_spurious_post: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    (a_free_o && !(byp_mode_i && !a_en_ni && !a_rw_i)) |=> a_free_o);

  a_r5_pending_kept: assert property (@(posedge clk_a_i) disable iff (!rst_ni)
    !a_free_o |=> $stable(mbox_q));

  a_r3_avail_drops: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    (b_avail_o && !b_en_ni && b_rw_i) |=> !b_avail_o);

  a_r7_data_hold: assert property (@(posedge clk_b_i) disable iff (!rst_ni)
    !(b_avail_o && !b_en_ni && b_rw_i) |=> $stable(b_data_o));
endmodule

bind bypass_mailbox bypass_mailbox_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_a_i    (clk_a_i),
  .clk_b_i    (clk_b_i),
  .rst_ni     (rst_ni),
  .byp_mode_i (byp_mode_i),
  .a_en_ni    (a_en_ni),
  .a_rw_i     (a_rw_i),
  .a_free_o   (a_free_o),
  .b_en_ni    (b_en_ni),
  .b_rw_i     (b_rw_i),
  .b_data_o   (b_data_o),
  .b_avail_o  (b_avail_o),
  .mbox_q     (mbox_q)
);

// File: tb/test_bypass_mailbox.sv
`timescale 1ns/1ps
module test_bypass_mailbox;
  localparam int W = 18;

  logic clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
  logic byp = 1'b0, a_en_n = 1'b1, a_rw = 1'b1, b_en_n = 1'b1, b_rw = 1'b0;
  logic [W-1:0] a_data = '0;
  logic [W-1:0] b_data;
  logic a_free, b_avail, b_byp_n;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk_a = ~clk_a;
  always #3.5 clk_b = ~clk_b;

  bypass_mailbox i_bypass_mailbox (
    .clk_a_i(clk_a), .clk_b_i(clk_b), .rst_ni(rst_n),
    .byp_mode_i(byp), .a_en_ni(a_en_n), .a_rw_i(a_rw), .a_data_i(a_data),
    .a_free_o(a_free), .b_en_ni(b_en_n), .b_rw_i(b_rw),
    .b_data_o(b_data), .b_avail_o(b_avail), .b_byp_no(b_byp_n)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one clk_a cycle of write strobe; caller chooses qualifiers
  task automatic a_strobe(logic mode, logic en_n, logic rw, logic [W-1:0] d);
    @(negedge clk_a);
    byp = mode; a_en_n = en_n; a_rw = rw; a_data = d;
    @(negedge clk_a);
    a_en_n = 1'b1; a_rw = 1'b1;
  endtask

  task automatic b_strobe(logic en_n, logic rw);
    @(negedge clk_b);
    b_en_n = en_n; b_rw = rw;
    @(negedge clk_b);
    b_en_n = 1'b1; b_rw = 1'b0;
  endtask

  // counts clk_b negedges until avail; strobe ended at a clk_a negedge after the write edge
  task automatic wait_avail(output int n);
    n = 0;
    while (!b_avail && n < 8) begin @(negedge clk_b); n++; end
  endtask

  task automatic wait_free(output int n);
    n = 0;
    while (!a_free && n < 8) begin @(negedge clk_a); n++; end
  endtask

  task automatic round_trip(logic [W-1:0] d);
    int n;
    a_strobe(1'b1, 1'b0, 1'b0, d);
    check("R1 free low after write", a_free, 0);
    wait_avail(n);
    check("R2 avail within 3 clk_b edges", (n <= 3), 1);
    b_strobe(1'b0, 1'b1);
    check("R3 read data", b_data, d);
    check("R3 avail low after read", b_avail, 0);
    wait_free(n);
    check("R4 free within 4 clk_a edges", (n <= 4), 1);
    repeat (3) @(negedge clk_b);
    check("R10 no second read offered", b_avail, 0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int n;
    logic [W-1:0] last;
    #1;
    check("R9 avail in reset", b_avail, 0);
    check("R9 free in reset", a_free, 1);
    check("R9 data in reset", b_data, 0);
    check("R9 byp_n in reset", b_byp_n, 1);
    #20 rst_n = 1'b1;
    repeat (3) @(negedge clk_b);

    // R8 indicator both directions
    @(negedge clk_a); byp = 1'b1;
    repeat (3) @(negedge clk_b);
    check("R8 byp_n low in bypass", b_byp_n, 0);
    @(negedge clk_a); byp = 1'b0;
    repeat (3) @(negedge clk_b);
    check("R8 byp_n high out of bypass", b_byp_n, 1);
    @(negedge clk_a); byp = 1'b1;
    repeat (3) @(negedge clk_b);

    // main sweep
    for (int i = 0; i < W; i++) round_trip(W'(1) << i);
    for (int i = 0; i < W; i++) round_trip(~(W'(1) << i));
    round_trip('0);
    round_trip('1);

    // R6 disqualified writes
    a_strobe(1'b0, 1'b0, 1'b0, 18'h15A5A);
    repeat (4) @(negedge clk_b);
    check("R6 mode off: free", a_free, 1);
    check("R6 mode off: avail", b_avail, 0);
    a_strobe(1'b1, 1'b1, 1'b0, 18'h15A5A);
    repeat (4) @(negedge clk_b);
    check("R6 enable high: free", a_free, 1);
    check("R6 enable high: avail", b_avail, 0);
    a_strobe(1'b1, 1'b0, 1'b1, 18'h15A5A);
    repeat (4) @(negedge clk_b);
    check("R6 direction read: free", a_free, 1);
    check("R6 direction read: avail", b_avail, 0);

    // R7 read when empty
    last = b_data;
    b_strobe(1'b0, 1'b1);
    check("R7 empty read keeps data", b_data, last);

    // R5 write while pending, R7 disqualified reads
    a_strobe(1'b1, 1'b0, 1'b0, 18'h2AAAA);
    a_strobe(1'b1, 1'b0, 1'b0, 18'h05555);
    wait_avail(n);
    check("R2 avail after pending write", b_avail, 1);
    last = b_data;
    b_strobe(1'b1, 1'b1);
    check("R7 enable high: avail kept", b_avail, 1);
    check("R7 enable high: data kept", b_data, last);
    b_strobe(1'b0, 1'b0);
    check("R7 direction write: avail kept", b_avail, 1);
    check("R7 direction write: data kept", b_data, last);
    check("R5 free still low while pending", a_free, 0);
    b_strobe(1'b0, 1'b1);
    check("R5 first word kept", b_data, 18'h2AAAA);
    wait_free(n);
    repeat (4) @(negedge clk_b);
    check("R10 second write not posted", b_avail, 0);

    finish_run();
  end
endmodule